// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block sits behind an infrared demodulator and turns the line's activity into a stream of timed records. The line is active-low: a low level is a mark (carrier burst present) and a high level is a space or idle. A prescaler divides the system clock down to a one-microsecond tick, and a tick counter measures the time between edges. Each edge produces a one-cycle record carrying the level of the interval that just ended (1 for mark, 0 for space) and its width in ticks.

The counter is cleared by each rising edge, which ends a mark. A falling edge, which ends a space, therefore reports the counter value directly and saves it. The following rising edge reports the counter value minus that saved capture. A programmable timeout in ticks raises a one-cycle end-of-frame pulse once the line has been idle long enough. The pulse is suppressed if the line is low at the compare instant. The input passes through a two-stage synchroniser before edge detection. Decoding of protocols and storage of records belong to the consumer.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset, `rec_valid` and `frame_end` are low.
- R2: A falling edge on the synchronised line emits a record with `rec_level`=0 and `rec_width` equal to the ticks counted since the previous rising edge, which zeroed both the counter and the prescaler.
- R3: A rising edge emits a record with `rec_level`=1 and `rec_width` equal to the counter value at that edge minus the value captured at the last falling edge, taken modulo 2^CNT_W.
- R4: The counter advances by one every CLK_DIV clock cycles, so widths scale with the prescaler.
- R5: The counter steps from CNT_MAX back to 0 rather than running through the full CNT_W range.
- R6: When the counter equals a nonzero `timeout_us` while the synchronised line is high, `frame_end` pulses high for exactly one cycle. A value of 0 disables the timeout.
- R7: If the line is low when the counter equals `timeout_us`, no `frame_end` is produced.
- R8: The timeout fires at most once between two edges, even if the counter wraps and meets the compare value again. Any edge rearms it.
- R9: While `en` is low, no record and no `frame_end` are produced, and the counter, prescaler and saved capture are held at 0. Counting resumes on the first clock edge with `en` high.
- R10: A record is valid on the third clock edge after the edge's input change: two synchroniser stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable; low clears timing state |
| ir_in | input | 1 | Demodulated infrared line, low = mark |
| timeout_us | input | CNT_W | Idle timeout in ticks, 0 = off |
| rec_valid | output | 1 | One-cycle strobe for a record |
| rec_level | output | 1 | Level of the measured interval, 1 = mark |
| rec_width | output | CNT_W | Width of the measured interval in ticks |
| frame_end | output | 1 | One-cycle idle-timeout pulse |

## Verification
The assertions assume that `ir_in` holds each level for at least two clock cycles, so that every synchronised edge is a single clean transition. They also assume that `timeout_us` is steady while the block is enabled. The stimulus changes `ir_in` and `en` only on falling clock edges, keeps every interval several cycles long, and sets `timeout_us` once before enabling. Widths are predicted from the cycle distance between input changes, the prescale ratio and the wrap limit.

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture #(
  parameter int CNT_W = 32,
  parameter int CLK_DIV = 64,
  parameter logic [CNT_W-1:0] CNT_MAX = CNT_W'(32'h7FFF_FFFE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ir_in,
  input  logic [CNT_W-1:0] timeout_us,
  output logic             rec_valid,
  output logic             rec_level,
  output logic [CNT_W-1:0] rec_width,
  output logic             frame_end
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [2:0]       sync_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q, fall_cap_q;
  logic             armed_q;

  wire line = sync_q[1];
  wire rise = en &  line & ~sync_q[2];
  wire fall = en & ~line &  sync_q[2];
  wire tick = (div_q == DIV_LAST);
  wire hit  = en & armed_q & (timeout_us != '0) & (cnt_q == timeout_us);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], ir_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (!en || rise) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      cnt_q <= (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    fall_cap_q <= '0;
    else if (!en)  fall_cap_q <= '0;
    else if (fall) fall_cap_q <= cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  armed_q <= 1'b1;
    else if (!en || rise || fall) armed_q <= 1'b1;
    else if (hit)                armed_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_level <= 1'b0;
      rec_width <= '0;
      frame_end <= 1'b0;
    end else begin
      rec_valid <= rise | fall;
      frame_end <= hit & line;
      if (rise | fall) begin
        rec_level <= rise;
        rec_width <= rise ? cnt_q - fall_cap_q : cnt_q;
      end
    end
endmodule

// File: rtl/ir_pulse_capture_chk.sv
module ir_pulse_capture_chk #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] CNT_MAX = CNT_W'(32'h7FFF_FFFE)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             line,
  input logic             rec_valid,
  input logic             rec_level,
  input logic [CNT_W-1:0] rec_width,
  input logic             frame_end
);
  a_r6_frame_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  a_r7_frame_end_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(line));

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!rec_valid && !frame_end));

  a_r3_level_tracks_line: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_level == $past(line)));

  a_r10_record_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> ($past(line) != $past(line, 2)));

  a_r5_space_within_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_level) |-> (rec_width <= CNT_MAX));
endmodule

bind ir_pulse_capture ir_pulse_capture_chk #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .line(sync_q[1]),
  .rec_valid(rec_valid), .rec_level(rec_level), .rec_width(rec_width),
  .frame_end(frame_end)
);

// File: tb/ir_pulse_capture_bench.sv
module ir_pulse_capture_bench;
  localparam int W = 32;
  localparam int DIV = 4;
  localparam int MAXC = 1000;
  localparam int TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ir_in = 1'b1;
  logic [W-1:0] timeout_us = '0;
  logic rec_valid, rec_level, frame_end;
  logic [W-1:0] rec_width;

  always #4 clk = ~clk;

  ir_pulse_capture #(.CNT_W(W), .CLK_DIV(DIV), .CNT_MAX(W'(MAXC))) u_ir_pulse_capture (
    .clk(clk), .rst_n(rst_n), .en(en), .ir_in(ir_in), .timeout_us(timeout_us),
    .rec_valid(rec_valid), .rec_level(rec_level), .rec_width(rec_width),
    .frame_end(frame_end)
  );

  typedef struct { logic lvl; logic [W-1:0] wid; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, fe_seen = 0, rec_seen = 0;

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (frame_end) fe_seen++;
    if (rec_valid) begin
      rec_seen++;
      if (exp_q.size() == 0) check(0, "R9 unexpected record", rec_width, -1);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rec_level == e.lvl, {e.req, " level"}, rec_level, e.lvl);
        check(rec_width == e.wid, {e.req, " width"}, rec_width, e.wid);
      end
    end
  end

  function automatic longint ticks(longint cyc);
    return (cyc / DIV) % (MAXC + 1);
  endfunction

  // space: cycles from previous rise (or enable) to fall; off=3 when timing from enable
  task automatic pulse(int space, int mark, int off, int pre, string req);
    longint sw, tw;
    sw = ticks(space - 1 + off);
    tw = ticks(space + mark - 1 + off);
    exp_q.push_back('{1'b0, W'(sw), {req, " R2 space"}});
    exp_q.push_back('{1'b1, W'(tw) - W'(sw), {req, " R3 mark"}});
    repeat (space - pre) @(negedge clk);
    ir_in = 1'b0;
    repeat (mark) @(negedge clk);
    ir_in = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int fe0, rc0;
    repeat (3) @(negedge clk);
    check(rec_valid == 1'b0, "R1 rec_valid", rec_valid, 0);
    check(frame_end == 1'b0, "R1 frame_end", frame_end, 0);
    rst_n = 1'b1;
    timeout_us = W'(TMO);
    @(negedge clk);
    en = 1'b1;
    fe0 = fe_seen;
    pulse(10, 12, 3, 0, "R4 first");
    pulse(9, 5, 0, 0, "R4 a");
    pulse(17, 33, 0, 0, "R4 b");
    pulse(41, 8, 0, 0, "R4 c");
    pulse(4, 4, 0, 0, "R4 d");
    pulse(61, 70, 0, 0, "R7 long mark");
    check(fe_seen == fe0, "R7 no timeout in mark", fe_seen - fe0, 0);
    repeat (100) @(negedge clk);
    check(fe_seen == fe0 + 1, "R6 idle timeout", fe_seen - fe0, 1);
    repeat (4500) @(negedge clk);
    check(fe_seen == fe0 + 1, "R8 no refire after wrap", fe_seen - fe0, 1);
    pulse(4609, 8, 0, 4600, "R5 wrap");
    repeat (100) @(negedge clk);
    check(fe_seen == fe0 + 2, "R8 rearm after edge", fe_seen - fe0, 2);

    en = 1'b0;
    fe0 = fe_seen;
    rc0 = rec_seen;
    repeat (10) @(negedge clk); ir_in = 1'b0;
    repeat (10) @(negedge clk); ir_in = 1'b1;
    repeat (10) @(negedge clk); ir_in = 1'b0;
    repeat (10) @(negedge clk);
    check(rec_seen == rc0, "R9 no records while off", rec_seen - rc0, 0);
    check(fe_seen == fe0, "R9 no timeout while off", fe_seen - fe0, 0);
    en = 1'b1;
    exp_q.push_back('{1'b1, W'((30 + 2) / DIV), "R9 cleared capture"});
    repeat (30) @(negedge clk);
    ir_in = 1'b1;

    exp_q.push_back('{1'b0, W'(11 / DIV), "R10 space"});
    repeat (12) @(negedge clk);
    ir_in = 1'b0;
    @(negedge clk);
    check(rec_valid == 1'b0, "R10 latency 1", rec_valid, 0);
    @(negedge clk);
    check(rec_valid == 1'b0, "R10 latency 2", rec_valid, 0);
    @(negedge clk);
    check(rec_valid == 1'b1, "R10 latency 3", rec_valid, 1);
    exp_q.push_back('{1'b1, W'((12 + 6 - 1) / DIV - 11 / DIV), "R3 after R10"});
    repeat (3) @(negedge clk);
    ir_in = 1'b1;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R2 all records seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule